// File: doc/BRIEF.md
# TDM Baseband Input Demultiplexer

This block sits at the entry of a transmit datapath and takes a time-division multiplexed stream of complex baseband words, one word per clock. A frame strobe, sampled on the same clock as the data, marks the first slot of each multiplex frame. Each word on the 18-bit input bus holds a 16-bit sample in its upper bits and two independent transmit sync reference levels in its lowest two bits. The block counts slots from the strobe, pairs the in-phase and quadrature words of each channel, and presents one complete channel sample with its channel index and a single-cycle valid flag.

The sync reference levels are not sample data. Each one is turned into a one-cycle pulse on its rising edge. If a strobe lands anywhere other than the expected first slot of a frame, the block realigns at once and raises a sticky misalignment flag. The flag stays set until reset. If strobes stop, the slot count wraps by itself, so the channel order is kept.

The output has no ready input. A multiplexed source of this kind cannot be paused, so a word arrives on every clock. The consumer must accept each valid sample in the cycle it is presented. For this reason the valid/ready convention is reduced to valid only at this edge.

Top module: `bb_tdm_demux`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it, out_valid, sync_pulse and misalign are all 0.
- R2: The sample is bus_data[17:2] and is taken from the bus in every slot. Slot 2k carries the I word and slot 2k+1 carries the Q word of channel k. One clock after the Q slot, out_valid is 1 with out_ch = k, out_i = the I word and out_q = the Q word.
- R3: out_valid is high for exactly one cycle per channel. It is 0 in the cycle after an I slot.
- R4: The word presented in the same cycle as frame_start is slot 0, which is the I word of channel 0.
- R5: When no strobe arrives, the slot after slot 2*NUM_CH-1 is slot 0, so channels repeat in order.
- R6: A frame_start that arrives when the expected slot is not 0 restarts the count at slot 0. It sets misalign one clock later, and misalign stays 1 until reset.
- R7: The first frame_start after reset never sets misalign, whatever the slot position it lands on.
- R8: On a restart, an I word that was captured before the restart and has no Q yet is dropped. No output is produced for it.
- R9: bus_data[0] drives sync_pulse[0] and bus_data[1] drives sync_pulse[1]. A 0-to-1 change of a sync bit between two consecutive words gives exactly one cycle of the matching sync_pulse bit, one clock after the word where the bit rose. A bit held high gives no further pulse. The sync bits have no effect on out_i or out_q.
- R10: A frame_start that lands on the expected slot 0 leaves misalign at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baseband clock; one bus word per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 18 | Multiplexed word: sample in [17:2], sync references in [1:0] |
| frame_start | input | 1 | High with the first word of a multiplex frame |
| out_valid | output | 1 | One-cycle flag: a complete channel sample is presented |
| out_ch | output | CH_W | Channel index of the presented sample |
| out_i | output | 16 | In-phase sample |
| out_q | output | 16 | Quadrature sample |
| sync_pulse | output | 2 | One-cycle pulse per rising sync reference bit |
| misalign | output | 1 | Sticky flag: a strobe arrived away from slot 0 |

## Verification
The hardest case to reach from the ports is a restart that falls on a Q slot. In that case a captured I word is waiting for its partner and must be dropped, and the word that arrives with the strobe must become channel 0's I. The bench reaches this by sending an aligned frame and stopping after the I word of channel 1. It then raises the strobe on the next word, which would have been that channel's Q. It checks that no output appears for that word, that the next word completes channel 0 with the strobe word as I, and that misalign rises and then stays set. A separate run places the first strobe after reset at a non-zero slot, to show that initial alignment is not reported as an error.

// File: rtl/tdm_demux_pkg.sv
package tdm_demux_pkg;
  localparam int BUS_W      = 18;
  localparam int SYNC_W     = 2;
  localparam int SAMPLE_W   = BUS_W - SYNC_W;
  localparam int SAMPLE_LSB = SYNC_W;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [SYNC_W-1:0]   sync_t;

  typedef struct packed {
    sample_t i;
    sample_t q;
  } iq_word_t;
endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              misalign
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] expect_q;
  logic              seen_q;
  logic              mis_q;

  // the strobe forces the current word into slot 0
  always_comb begin
    cur_slot = frame_start ? '0 : expect_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= '0;
      seen_q   <= 1'b0;
      mis_q    <= 1'b0;
    end else begin
      expect_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
      if (frame_start) seen_q <= 1'b1;
      if (frame_start && seen_q && (expect_q != '0)) mis_q <= 1'b1;
    end
  end

  assign misalign = mis_q;
endmodule

// File: rtl/tdm_iq_pair.sv
module tdm_iq_pair
  import tdm_demux_pkg::*;
#(
  parameter int SLOT_W = 3,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  sample_t           sample,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output iq_word_t          out_iq
);
  sample_t           held_i;
  logic              is_q_slot;
  logic [SLOT_W-1:0] ch_full;

  always_comb begin
    is_q_slot = slot[0];
    ch_full   = slot >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_i    <= '0;
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_iq    <= '0;
    end else begin
      out_valid <= is_q_slot;
      if (!is_q_slot) begin
        held_i <= sample;
      end else begin
        out_ch   <= ch_full[CH_W-1:0];
        out_iq.i <= held_i;
        out_iq.q <= sample;
      end
    end
  end
endmodule

// File: rtl/tdm_sync_edge.sv
module tdm_sync_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] pulse
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic prev_q;
    logic pulse_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        prev_q  <= level[b];
        pulse_q <= level[b] & ~prev_q;
      end
    end
    assign pulse[b] = pulse_q;
  end
endmodule

// File: rtl/bb_tdm_demux.sv
module bb_tdm_demux
  import tdm_demux_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              frame_start,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic [SYNC_W-1:0] sync_pulse,
  output logic              misalign
);
  localparam int NUM_SLOTS = 2 * NUM_CH;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  logic [SLOT_W-1:0] cur_slot;
  sample_t           sample;
  sync_t             sync_lvl;
  iq_word_t          iq;

  assign sample   = bus_data[BUS_W-1:SAMPLE_LSB];
  assign sync_lvl = bus_data[SYNC_W-1:0];

  tdm_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cur_slot(cur_slot), .misalign(misalign)
  );

  tdm_iq_pair #(.SLOT_W(SLOT_W), .CH_W(CH_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .slot(cur_slot), .sample(sample),
    .out_valid(out_valid), .out_ch(out_ch), .out_iq(iq)
  );

  tdm_sync_edge #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .level(sync_lvl), .pulse(sync_pulse)
  );

  assign out_i = iq.i;
  assign out_q = iq.q;
endmodule

// File: rtl/bb_tdm_demux_chk.sv
module bb_tdm_demux_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [17:0]     bus_data,
  input logic            frame_start,
  input logic            out_valid,
  input logic [CH_W-1:0] out_ch,
  input logic [1:0]      sync_pulse,
  input logic            misalign
);
  // R3: a channel sample is never presented on two cycles in a row
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2: presented channel index stays inside the configured count
  a_r2_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ch <= CH_W'(NUM_CH - 1)));

  // R6: misalignment flag is sticky
  a_r6_misalign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign);

  // R6: flag only rises right after a strobe
  a_r6_misalign_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(misalign) |-> $past(frame_start));

  // R9: each sync pulse lasts one cycle and follows a high sync bit
  a_r9_sync0_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse[0] |=> !sync_pulse[0]);
  a_r9_sync1_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse[1] |=> !sync_pulse[1]);
  a_r9_sync0_source: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse[0] |-> $past(bus_data[0]));
  a_r9_sync1_source: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse[1] |-> $past(bus_data[1]));
endmodule

bind bb_tdm_demux bb_tdm_demux_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .frame_start(frame_start),
  .out_valid(out_valid), .out_ch(out_ch), .sync_pulse(sync_pulse),
  .misalign(misalign)
);

// File: tb/bb_tdm_demux_tb_top.sv
`timescale 1ns/1ps
module bb_tdm_demux_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] bus_data = '0;
  logic        frame_start = 1'b0;
  logic        out_valid;
  logic [1:0]  out_ch;
  logic [15:0] out_i, out_q;
  logic [1:0]  sync_pulse;
  logic        misalign;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bb_tdm_demux #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .frame_start(frame_start),
    .out_valid(out_valid), .out_ch(out_ch), .out_i(out_i), .out_q(out_q),
    .sync_pulse(sync_pulse), .misalign(misalign)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one bus word at the falling edge, then sample the registered result
  task automatic push(input logic [15:0] s, input logic [1:0] sy, input logic fs);
    @(negedge clk);
    bus_data    = {s, sy};
    frame_start = fs;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_start = 1'b0; bus_data = '0;
    #1;
    check("R1", "valid in reset", out_valid, 0);
    check("R1", "sync in reset", sync_pulse, 0);
    check("R1", "misalign in reset", misalign, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R7, R2, R3, R4, R10: late first strobe, then an aligned frame
  task automatic t_first_frame();
    for (int w = 0; w < 3; w++) push(16'h0dd0 + 16'(w), 2'b00, 1'b0);
    push(16'h1000, 2'b00, 1'b1);
    check("R7", "first strobe misalign", misalign, 0);
    check("R4", "no valid after strobe word", out_valid, 0);
    for (int k = 0; k < NCH; k++) begin
      if (k > 0) begin
        push(16'h1000 + 16'(k), 2'b00, 1'b0);
        check("R3", "no valid after I slot", out_valid, 0);
      end
      push(16'h2000 + 16'(k), 2'b00, 1'b0);
      check("R2", "valid after Q slot", out_valid, 1);
      check("R2", "channel", out_ch, k);
      check("R2", "I word", out_i, 16'h1000 + 16'(k));
      check("R2", "Q word", out_q, 16'h2000 + 16'(k));
    end
    push(16'h3000, 2'b00, 1'b1);
    check("R10", "aligned strobe misalign", misalign, 0);
    push(16'h4000, 2'b00, 1'b0);
    check("R4", "strobe word is ch0 I", out_i, 16'h3000);
    check("R4", "ch0 index", out_ch, 0);
    for (int w = 0; w < 2 * NCH - 2; w++) push(16'h5000 + 16'(w), 2'b00, 1'b0);
  endtask

  // R5: a frame with no strobe wraps into channel 0 again
  task automatic t_free_wrap();
    for (int k = 0; k < NCH; k++) begin
      push(16'h6100 + 16'(k), 2'b00, 1'b0);
      push(16'h6200 + 16'(k), 2'b00, 1'b0);
      check("R5", "wrap valid", out_valid, 1);
      check("R5", "wrap channel", out_ch, k);
      check("R5", "wrap I", out_i, 16'h6100 + 16'(k));
      check("R5", "wrap Q", out_q, 16'h6200 + 16'(k));
    end
  endtask

  // R9: sync bits make single pulses and leave the sample untouched
  task automatic t_sync();
    logic [1:0] pat [8] = '{2'b00, 2'b01, 2'b01, 2'b11, 2'b10, 2'b00, 2'b10, 2'b00};
    logic [1:0] prev = 2'b00;
    for (int w = 0; w < 8; w++) begin
      push(16'h7000 + 16'(w), pat[w], 1'b0);
      check("R9", "sync pulse", sync_pulse, pat[w] & ~prev);
      if (w[0]) begin
        check("R9", "I unaffected", out_i, 16'h7000 + 16'(w - 1));
        check("R9", "Q unaffected", out_q, 16'h7000 + 16'(w));
      end
      prev = pat[w];
    end
  endtask

  // R6, R8: strobe on a Q slot drops the pending I and sets the sticky flag
  task automatic t_restart();
    push(16'h8000, 2'b00, 1'b1);
    push(16'h8001, 2'b00, 1'b0);
    push(16'h8002, 2'b00, 1'b0);
    check("R10", "misalign before restart", misalign, 0);
    push(16'h8aaa, 2'b00, 1'b1);
    check("R8", "no output for dropped I", out_valid, 0);
    check("R6", "misalign set", misalign, 1);
    push(16'h8bbb, 2'b00, 1'b0);
    check("R6", "restart valid", out_valid, 1);
    check("R6", "restart channel", out_ch, 0);
    check("R8", "restart I", out_i, 16'h8aaa);
    check("R8", "restart Q", out_q, 16'h8bbb);
    push(16'h8ccc, 2'b00, 1'b0);
    push(16'h8ddd, 2'b00, 1'b0);
    check("R6", "next channel after restart", out_ch, 1);
    check("R6", "misalign sticky", misalign, 1);
  endtask

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual=hung expected=finished");
          $display("Result: errors=%0d of %0d checks", errors, checks + 1);
          $finish;
        end
      end
    join_none
    do_reset();
    t_first_frame();
    t_free_wrap();
    t_sync();
    t_restart();
    do_reset();
    @(posedge clk); #1;
    check("R1", "misalign cleared by reset", misalign, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule